// File: doc/BRIEF.md
# Quadrature 4x Decoder Counter

This block rebuilds a parallel position word from a pair of incremental channels, A and B, on the host side of a position link. Both channels are brought into the system clock domain. Every rising and falling edge on either channel counts as one event, so one full A/B cycle moves the count by four. The count is held in a wrapping up/down register.

The direction of each count comes from one of two places. By default it is decoded from the channel phase: the edge is combined with the level of the other channel. When the mode input selects it, an external direction line sets up or down directly and the channel phase is ignored. A sample in which both channels change at once cannot be decoded. Such a sample raises a one-cycle error pulse and does not count.

Top module: `quad_pos_counter`

## Requirements
- R1: While `rst_n` is low, `pos_cnt` reads 0 and `illegal` reads 0.
- R2: Each rising or falling edge on `chan_a` or `chan_b` moves `pos_cnt` by exactly one, so one full A/B cycle moves it by four.
- R3: With `dir_sel` = 0, the state sequence (A,B) = 00, 01, 11, 10, 00 (B leading A) increments `pos_cnt`, and the reverse sequence decrements it.
- R4: With `dir_sel` = 0, an edge on A counts up when the new A equals B, and an edge on B counts up when the new B differs from A. A reversal in the middle of a cycle therefore undoes the previous count.
- R5: With `dir_sel` = 1, every edge counts up when `dir_ext` = 1 and down when `dir_ext` = 0, whatever the channel phase.
- R6: If A and B both change between two consecutive samples, `illegal` is 1 for exactly one cycle and `pos_cnt` does not change.
- R7: `pos_cnt` wraps modulo 2^CNT_W: one down count from 0 gives 4095, and one up count from 4095 gives 0 (CNT_W = 12).
- R8: A channel change applied between clock edges shows on `pos_cnt` and `illegal` at the (SYNC_STAGES+1)-th rising edge after it, and not before.
- R9: While no channel changes, `pos_cnt` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| chan_a | input | 1 | Incremental channel A, asynchronous |
| chan_b | input | 1 | Incremental channel B, asynchronous |
| dir_ext | input | 1 | External direction, 1 = up, used when `dir_sel` = 1 |
| dir_sel | input | 1 | 0 = direction from channel phase, 1 = direction from `dir_ext` |
| pos_cnt | output | CNT_W | Parallel position count |
| illegal | output | 1 | One-cycle pulse when both channels change in one sample |

## Verification
The bench uses the default parameters: a 12-bit count and two synchronizer stages. With these values the wrap in both directions can be reached with a single step from 0. The decode latency is three edges, which the bench checks one cycle early, on time and one cycle late for every step. Phase-decoded steps, mid-cycle reversals, externally directed steps and double-change samples are all driven through the same synchronizer path, so each outcome is seen at the ports.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/qd_rst_sync.sv
module qd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shreg_q;
  logic [STAGES-1:0] shreg_d;

  always_comb begin
    shreg_d = {shreg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  assign rst_sync_n = shreg_q[STAGES-1];
endmodule

// File: rtl/qd_sync.sv
module qd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qd_edge_dec.sv
module qd_edge_dec
  import qd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_s,
  input  logic  b_s,
  input  logic  dir_ext_s,
  input  logic  dir_sel_s,
  output step_e step,
  output logic  illegal
);
  logic a_prev_q, b_prev_q;
  logic err_q, err_d;
  logic edge_a, edge_b, phase_up, go_up;

  always_comb begin
    edge_a   = a_s ^ a_prev_q;
    edge_b   = b_s ^ b_prev_q;
    // A edge: up when new A matches B; B edge: up when new B differs from A
    phase_up = edge_a ? (a_s == b_s) : (b_s != a_s);
    go_up    = dir_sel_s ? dir_ext_s : phase_up;
    err_d    = edge_a & edge_b;
    if (edge_a & edge_b)      step = STEP_NONE;
    else if (edge_a | edge_b) step = go_up ? STEP_UP : STEP_DN;
    else                      step = STEP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      a_prev_q <= a_s;
      b_prev_q <= b_s;
      err_q    <= err_d;
    end
  end

  assign illegal = err_q;
endmodule

// File: rtl/qd_updown.sv
module qd_updown
  import qd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (step != STEP_NONE);
    cnt_d  = (step == STEP_UP) ? cnt_q + ONE : cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qd_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_a,
  input  logic             chan_b,
  input  logic             dir_ext,
  input  logic             dir_sel,
  output logic [CNT_W-1:0] pos_cnt,
  output logic             illegal
);
  localparam int NSIG = 4;

  logic            rst_int_n;
  logic [NSIG-1:0] raw_in, sync_in;
  step_e           step_w;

  qd_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  assign raw_in = {dir_sel, dir_ext, chan_b, chan_a};

  qd_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_int_n), .d(raw_in), .q(sync_in)
  );

  qd_edge_dec dec_i (
    .clk(clk), .rst_n(rst_int_n),
    .a_s(sync_in[0]), .b_s(sync_in[1]),
    .dir_ext_s(sync_in[2]), .dir_sel_s(sync_in[3]),
    .step(step_w), .illegal(illegal)
  );

  qd_updown #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_int_n), .step(step_w), .cnt(pos_cnt)
  );
endmodule

// File: rtl/qd_chk.sv
module qd_chk
  import qd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] pos_cnt,
  input logic             illegal,
  input step_e            step
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R1
  rst_clear_chk: assert property (@(posedge clk) !rst_n |-> (pos_cnt == '0 && !illegal));

  // R6
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> pos_cnt == $past(pos_cnt));

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step == STEP_UP |=> pos_cnt == $past(pos_cnt) + ONE);

  // R3
  step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step == STEP_DN |=> pos_cnt == $past(pos_cnt) - ONE);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step == STEP_NONE |=> $stable(pos_cnt));
endmodule

bind quad_pos_counter qd_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pos_cnt(pos_cnt), .illegal(illegal), .step(step_w)
);

// File: tb/quad_pos_counter_tb_top.sv
module quad_pos_counter_tb_top;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n, a, b, dir_ext, dir_sel;
  logic [CW-1:0] pos;
  logic          ill;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int            due;
    logic [CW-1:0] cnt;
    logic          err;
    string         req;
  } exp_t;

  exp_t          sbq[$];
  exp_t          cur;
  logic [CW-1:0] m_cnt;
  logic          pa, pb;

  quad_pos_counter #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_a(a), .chan_b(b),
    .dir_ext(dir_ext), .dir_sel(dir_sel), .pos_cnt(pos), .illegal(ill)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(string req, logic [CW-1:0] act_c, logic [CW-1:0] exp_c,
                     logic act_e, logic exp_e);
    checks++;
    if (act_c !== exp_c || act_e !== exp_e) begin
      errors++;
      $display("FAIL %s: pos_cnt=%0d illegal=%0b, expected pos_cnt=%0d illegal=%0b",
               req, act_c, act_e, exp_c, exp_e);
    end
  endtask

  // monitor: pops expected items when they fall due
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      cur = sbq.pop_front();
      chk(cur.req, pos, cur.cnt, ill, cur.err);
    end
  end

  // driver: one channel sample change, expectations pushed to the scoreboard
  task automatic step(logic na, logic nb, string req);
    logic ea, eb, up, e;
    logic [CW-1:0] old_c;
    @(negedge clk);
    old_c = m_cnt;
    ea = (na != pa);
    eb = (nb != pb);
    e  = ea & eb;
    if (!e && (ea || eb)) begin
      up = dir_sel ? dir_ext : (ea ? (na == pb) : (nb != pa));
      m_cnt = up ? m_cnt + 1'b1 : m_cnt - 1'b1;
    end
    a = na; b = nb; pa = na; pb = nb;
    sbq.push_back('{cyc + 2, old_c, 1'b0, {req, " (R8 early)"}});
    sbq.push_back('{cyc + 3, m_cnt, e, req});
    sbq.push_back('{cyc + 4, m_cnt, 1'b0, {req, " (R8 after)"}});
    repeat (5) @(negedge clk);
  endtask

  task automatic set_mode(logic sel, logic de);
    @(negedge clk);
    dir_sel = sel; dir_ext = de;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; a = 1'b0; b = 1'b0; dir_ext = 1'b0; dir_sel = 1'b0;
    pa = 1'b0; pb = 1'b0; m_cnt = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset", pos, '0, ill, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", pos, '0, ill, 1'b0);

    // R3 B leads A: up
    step(0, 1, "R3 up 00->01");
    step(1, 1, "R3 up 01->11");
    step(1, 0, "R3 up 11->10");
    step(0, 0, "R3 up 10->00");
    chk("R2 full cycle is four", pos, 12'd4, ill, 1'b0);
    // R3 A leads B: down
    step(1, 0, "R3 down 00->10");
    step(1, 1, "R3 down 10->11");
    step(0, 1, "R3 down 11->01");
    step(0, 0, "R3 down 01->00");
    // R7 wrap both ways
    step(1, 0, "R7 wrap below zero");
    chk("R7 reads 4095", pos, 12'd4095, ill, 1'b0);
    step(0, 0, "R7 wrap above 4095");
    // R4 reversal mid-cycle
    step(0, 1, "R4 B edge up");
    step(0, 0, "R4 B edge reversed down");
    step(1, 0, "R4 A edge down");
    step(0, 0, "R4 A edge reversed up");
    // R9 idle
    repeat (10) @(negedge clk);
    chk("R9 idle hold", pos, m_cnt, ill, 1'b0);
    // R6 both change
    step(1, 1, "R6 double change 00->11");
    step(0, 0, "R6 double change 11->00");
    step(0, 1, "R6 count resumes");
    // R5 external direction
    set_mode(1'b1, 1'b0);
    step(1, 1, "R5 ext down on up-phase edge");
    step(1, 0, "R5 ext down on up-phase edge");
    step(0, 0, "R5 ext down on up-phase edge");
    set_mode(1'b1, 1'b1);
    step(1, 0, "R5 ext up on down-phase edge");
    step(1, 1, "R5 ext up on down-phase edge");
    step(0, 0, "R6 double change in ext mode");
    set_mode(1'b0, 1'b0);
    step(0, 1, "R3 phase mode restored");

    // R1 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset", pos, '0, ill, 1'b0);
    a = 1'b0; b = 1'b0; pa = 1'b0; pb = 1'b0; m_cnt = '0;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 held after release", pos, '0, ill, 1'b0);
    step(0, 1, "R2 count after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule